// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that runs entirely from its own slow clock, separate from the system bus clock. Software talks to it by writing a simple register bus in the bus clock domain. A write to the key register carries a 16-bit code. One code starts the watchdog. Another reloads ("feeds") the down-counter. A third opens the divider and reload registers for writing. Each bus write crosses into the watchdog domain through a toggle flag and a two-flop synchronizer, while the write's address and data are held steady in the bus domain.

Inside the watchdog domain, a prescaler divides the slow clock by 4·2^prer, where prer runs from 0 to 7. Each prescaler period takes one step off a 12-bit down-counter. When the counter has reached zero while the watchdog runs, a reset request is raised. The request stays high until the system reset clears it. Once the watchdog has started, no key write can stop it. Software has to feed it within (4·2^prer)·rlr slow-clock cycles of the last feed or start.

Top module: `wdg_top`

## Requirements
- R1: After system reset the reset request output is low and the watchdog is stopped. While it stays stopped the request never rises. The divider field resets to 0 and the reload value resets to 0xFFF.
- R2: Writing 0xCCCC to the key register (address 0) starts the watchdog. If no reload happened before the start, the counter begins from 0xFFF. With prer=0 this gives a timeout of 4·4095 slow cycles.
- R3: Writing 0xAAAA to the key register copies the reload value into the counter and restarts the prescaler phase. This may be done any number of times, and feeding more often than the timeout keeps the request low.
- R4: The reset request rises on the slow-clock edge after the running counter is zero. It then stays high, whatever keys are written, until system reset.
- R5: The prescaler divides by 4·2^prer. After a start or feed takes effect, the request rises (4·2^prer)·rlr+1 slow cycles later. Measured from the bus write, this is between (4·2^prer)·rlr+2 and (4·2^prer)·rlr+7 slow cycles. The counter only steps down by one, and only on a prescaler tick.
- R6: Writing 0x5555 to the key register unlocks the divider register (address 1, bits [2:0]) and the reload register (address 2, bits [11:0]). While locked, writes to these two addresses are ignored.
- R7: Writing any key value other than 0x5555, including 0xAAAA, locks the divider and reload registers again.
- R8: Once started, the watchdog stays running. No key value written afterwards stops it or keeps it from timing out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset, held for several cycles of both clocks |
| bus_we | input | 1 | Write strobe, one bus cycle per write, writes spaced by at least 16 bus cycles |
| bus_addr | input | 2 | Register select: 0 key, 1 divider, 2 reload, 3 unused |
| bus_wdata | input | 16 | Write data |
| wclk | input | 1 | Independent low-speed watchdog clock |
| wdg_rst_req | output | 1 | Registered, sticky reset request in the watchdog clock domain |

## Verification
On every slow-clock cycle, the assertions check these properties:
- the request is sticky, and it rises only from a zero count while the watchdog runs;
- the run state never clears;
- the locked registers hold still;
- a feed loads the reload value;
- the counter moves by at most one step, and only while running.

The actual timeout length for each divider setting, the start value of 0xFFF, and the relocking by a foreign key are end-to-end effects. Only the bench scenarios can show them, by timing the request against the bus writes.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_RLD  = 2'd2,
    SEL_NONE = 2'd3
  } wdg_sel_e;
endpackage

// File: rtl/wdg_bus_sync.sv
`timescale 1ns/1ps
// Carries a bus write into the slow domain: held data plus a toggled flag.
module wdg_bus_sync #(
  parameter int DW     = 16,
  parameter int AW     = 2,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          wclk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          cmd_vld,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  logic          flag_q;
  logic [AW-1:0] hold_a_q;
  logic [DW-1:0] hold_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      hold_a_q <= '0;
      hold_d_q <= '0;
    end else if (we) begin
      flag_q   <= ~flag_q;
      hold_a_q <= addr;
      hold_d_q <= wdata;
    end
  end

  logic [STAGES:0] sync_q;
  logic            edge_w;
  assign edge_w = sync_q[STAGES] ^ sync_q[STAGES-1];

  always_ff @(posedge wclk) begin
    if (rst) begin
      sync_q   <= '0;
      cmd_vld  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      sync_q  <= {sync_q[STAGES-1:0], flag_q};
      cmd_vld <= edge_w;
      if (edge_w) begin
        cmd_addr <= hold_a_q;
        cmd_data <= hold_d_q;
      end
    end
  end
endmodule

// File: rtl/wdg_keyregs.sv
`timescale 1ns/1ps
// Key decoding, lock state, run state, divider and reload registers.
module wdg_keyregs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PRE_W = 3
) (
  input  logic             wclk,
  input  logic             rst,
  input  logic             cmd_vld,
  input  logic [1:0]       cmd_addr,
  input  logic [KEY_W-1:0] cmd_data,
  output logic             run,
  output logic             open,
  output logic [PRE_W-1:0] prer,
  output logic [CNT_W-1:0] rlr,
  output logic             feed
);
  logic key_wr, div_wr, rld_wr;
  assign key_wr = cmd_vld && (cmd_addr == SEL_KEY);
  assign div_wr = cmd_vld && (cmd_addr == SEL_DIV) && open;
  assign rld_wr = cmd_vld && (cmd_addr == SEL_RLD) && open;
  assign feed   = key_wr && (cmd_data == KEY_FEED);

  always_ff @(posedge wclk) begin
    if (rst) begin
      run  <= 1'b0;
      open <= 1'b0;
      prer <= '0;
      rlr  <= '1;
    end else begin
      if (key_wr) begin
        open <= (cmd_data == KEY_OPEN);
        if (cmd_data == KEY_START) run <= 1'b1;
      end
      if (div_wr) prer <= cmd_data[PRE_W-1:0];
      if (rld_wr) rlr  <= cmd_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wdg_prediv.sv
`timescale 1ns/1ps
// Divides the slow clock by 4 * 2^prer into a one-cycle tick.
module wdg_prediv #(
  parameter int PRE_W = 3
) (
  input  logic             wclk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] prer,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  // Wraps to all ones for the largest ratio.
  assign lim  = (DIV_W'(4) << prer) - DIV_W'(1);
  assign tick = run && (div_q == lim);

  always_ff @(posedge wclk) begin
    if (rst || !run || restart) div_q <= '0;
    else if (div_q == lim)      div_q <= '0;
    else                        div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/wdg_downcnt.sv
`timescale 1ns/1ps
// Down-counter and sticky reset request.
module wdg_downcnt #(
  parameter int CNT_W = 12
) (
  input  logic             wclk,
  input  logic             rst,
  input  logic             run,
  input  logic             feed,
  input  logic             tick,
  input  logic [CNT_W-1:0] rlr,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);
  logic at_zero;
  assign at_zero = (cnt == '0);

  always_ff @(posedge wclk) begin
    if (rst) begin
      cnt  <= '1;
      fire <= 1'b0;
    end else begin
      if (feed)                 cnt <= rlr;
      else if (tick && !at_zero) cnt <= cnt - CNT_W'(1);
      if (run && at_zero) fire <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_top.sv
`timescale 1ns/1ps
module wdg_top
  import wdg_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PRE_W  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [KEY_W-1:0] bus_wdata,
  input  logic             wclk,
  output logic             wdg_rst_req
);
  logic             cmd_vld;
  logic [1:0]       cmd_addr;
  logic [KEY_W-1:0] cmd_data;
  logic             run, open, feed, tick, fire;
  logic [PRE_W-1:0] prer;
  logic [CNT_W-1:0] rlr, cnt;

  wdg_bus_sync #(.DW(KEY_W), .AW(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .wclk(wclk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  wdg_keyregs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .wclk(wclk), .rst(rst), .cmd_vld(cmd_vld), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .run(run), .open(open), .prer(prer), .rlr(rlr), .feed(feed)
  );

  wdg_prediv #(.PRE_W(PRE_W)) u_div (
    .wclk(wclk), .rst(rst), .run(run), .restart(feed), .prer(prer), .tick(tick)
  );

  wdg_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .wclk(wclk), .rst(rst), .run(run), .feed(feed), .tick(tick), .rlr(rlr),
    .cnt(cnt), .fire(fire)
  );

  assign wdg_rst_req = fire;
endmodule

// File: rtl/wdg_chk.sv
`timescale 1ns/1ps
module wdg_chk #(
  parameter int CNT_W = 12,
  parameter int PRE_W = 3
) (
  input logic             wclk,
  input logic             rst,
  input logic             run,
  input logic             open,
  input logic             feed,
  input logic             tick,
  input logic [PRE_W-1:0] prer,
  input logic [CNT_W-1:0] rlr,
  input logic [CNT_W-1:0] cnt,
  input logic             fire
);
  // R4
  fire_sticky_chk: assert property (@(posedge wclk) disable iff (rst)
    fire |=> fire);
  // R4
  fire_cause_chk: assert property (@(posedge wclk) disable iff (rst)
    $rose(fire) |-> $past(run && (cnt == '0)));
  // R8
  run_hold_chk: assert property (@(posedge wclk) disable iff (rst)
    run |=> run);
  // R6
  lock_hold_chk: assert property (@(posedge wclk) disable iff (rst)
    !open |=> ($stable(prer) && $stable(rlr)));
  // R3
  feed_load_chk: assert property (@(posedge wclk) disable iff (rst)
    feed |=> (cnt == $past(rlr)));
  // R5
  cnt_step_chk: assert property (@(posedge wclk) disable iff (rst)
    !feed |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1))));
  // R5
  tick_gate_chk: assert property (@(posedge wclk) disable iff (rst)
    !run |-> !tick);
endmodule

bind wdg_top wdg_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .wclk(wclk), .rst(rst), .run(run), .open(open), .feed(feed), .tick(tick),
  .prer(prer), .rlr(rlr), .cnt(cnt), .fire(fire)
);

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  logic        clk = 1'b0;
  logic        wclk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic        wdg_rst_req;

  int tests = 0;
  int fails = 0;
  int n, p, r, expv;
  bit done = 0;

  localparam logic [1:0] A_KEY = 2'd0, A_DIV = 2'd1, A_RLD = 2'd2;
  localparam int NV = 5;
  // {prer, rlr}
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 12'd5}, {3'd1, 12'd7}, {3'd2, 12'd4}, {3'd4, 12'd3}, {3'd7, 12'd2}
  };

  wdg_top u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wclk(wclk), .wdg_rst_req(wdg_rst_req)
  );

  always #4  clk  = ~clk;
  always #11 wclk = ~wclk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    put(a, d);
    repeat (16) @(negedge clk);
  endtask

  task automatic put_measure(input logic [15:0] key, input int limit, output int cnt);
    put(A_KEY, key);
    cnt = 0;
    while (!wdg_rst_req && cnt < limit) begin
      @(negedge wclk);
      cnt++;
    end
  endtask

  task automatic sys_reset();
    rst = 1'b1;
    repeat (6) @(negedge wclk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog timer expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    sys_reset();
    // R1: reset state and no firing while stopped
    check(wdg_rst_req == 1'b0, "R1 request low after reset", wdg_rst_req, 0);
    repeat (2500) @(negedge wclk);
    check(wdg_rst_req == 1'b0, "R1 request stays low while stopped", wdg_rst_req, 0);

    // R5: vector walk over divider settings
    for (int i = 0; i < NV; i++) begin
      p = int'(VEC[i][14:12]);
      r = int'(VEC[i][11:0]);
      expv = (4 << p) * r;
      sys_reset();
      wr(A_KEY, 16'h5555);
      wr(A_DIV, 16'(p));
      wr(A_RLD, 16'(r));
      wr(A_KEY, 16'hAAAA);
      put_measure(16'hCCCC, expv + 40, n);
      check(n >= expv + 2 && n <= expv + 7, $sformatf("R5 timeout prer=%0d rlr=%0d", p, r), n, expv + 4);
    end

    // R2: start without feed counts from 0xFFF at prer=0 (default divider, R1)
    sys_reset();
    expv = 4 * 4095;
    put_measure(16'hCCCC, expv + 40, n);
    check(n >= expv + 2 && n <= expv + 7, "R2 R1 start from default reload", n, expv + 4);

    // R6: writes while locked are ignored
    sys_reset();
    wr(A_KEY, 16'h5555);
    wr(A_RLD, 16'd5);
    wr(A_DIV, 16'd0);
    wr(A_KEY, 16'hAAAA);
    wr(A_RLD, 16'd100);
    wr(A_DIV, 16'd3);
    wr(A_KEY, 16'hAAAA);
    put_measure(16'hCCCC, 2000, n);
    check(n >= 22 && n <= 27, "R6 locked writes ignored", n, 24);

    // R7: a foreign key relocks
    sys_reset();
    wr(A_KEY, 16'h5555);
    wr(A_RLD, 16'd6);
    wr(A_KEY, 16'h1234);
    wr(A_RLD, 16'd40);
    wr(A_KEY, 16'hAAAA);
    put_measure(16'hCCCC, 2000, n);
    check(n >= 26 && n <= 31, "R7 foreign key relocks", n, 28);

    // R3: repeated feeds keep the request low
    sys_reset();
    wr(A_KEY, 16'h5555);
    wr(A_RLD, 16'd50);
    wr(A_KEY, 16'hAAAA);
    wr(A_KEY, 16'hCCCC);
    for (int k = 0; k < 4; k++) begin
      repeat (120) @(negedge wclk);
      wr(A_KEY, 16'hAAAA);
      check(wdg_rst_req == 1'b0, "R3 periodic feed holds off reset", wdg_rst_req, 0);
    end
    put_measure(16'hAAAA, 1000, n);
    check(n >= 202 && n <= 207, "R3 timeout after last feed", n, 204);

    // R4: sticky through further keys
    wr(A_KEY, 16'hAAAA);
    repeat (300) @(negedge wclk);
    check(wdg_rst_req == 1'b1, "R4 request sticky", wdg_rst_req, 1);
    sys_reset();
    check(wdg_rst_req == 1'b0, "R4 R1 cleared by system reset", wdg_rst_req, 0);

    // R8: no key stops a running watchdog
    wr(A_KEY, 16'h5555);
    wr(A_RLD, 16'd30);
    wr(A_KEY, 16'hAAAA);
    wr(A_KEY, 16'hCCCC);
    wr(A_KEY, 16'h0000);
    wr(A_KEY, 16'h5555);
    wr(A_KEY, 16'hFFFF);
    repeat (200) @(negedge wclk);
    check(wdg_rst_req == 1'b1, "R8 cannot be stopped", wdg_rst_req, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule